// File: doc/BRIEF.md
# Hamming 8/4 label decoder and output packer

This block takes the thirteen protected bytes (packet positions 13 through 25) of a format-2 broadcast data packet and turns them into a sixteen-byte output image. Each incoming byte carries four message bits under a Hamming 8/4 code. The block checks each byte and repairs any byte that has a single flipped bit. It then stores the recovered nibble. When the packet is complete, it merges pairs of nibbles into output bytes in a fixed, non-sequential order.

The output image is replaced only when every byte of the packet was clean or was repaired. A one-cycle commit strobe marks that update. If any byte cannot be repaired, or bytes arrive out of sequence, the whole packet is discarded: the image keeps its old contents and a one-cycle reject strobe fires instead. With either strobe the block reports how many bytes of the packet needed a repair.

The control is a four-state machine. Idle waits for position 13. Collect takes the following positions in order. Commit lasts one cycle and loads the image. Reject lasts one cycle and drops the packet. The transitions are:
- Idle to Collect, on a repairable byte at position 13.
- Idle to Reject, on an unrepairable byte at position 13.
- Collect to Commit, on a repairable byte at position 25.
- Collect to Reject, on a wrong position or an unrepairable byte.
- Commit to Idle and Reject to Idle, unconditionally.

Top module: `ham84_packer`

## Requirements
- R1: Coding: a byte is a valid codeword when four parity groups each hold an odd number of ones. The groups are bits {0,1,5,7}, bits {1,2,3,7}, bits {1,3,4,5} and all eight bits. Message bits 0 to 3 sit at byte bits 1, 3, 5 and 7, and a packet of valid codewords reports a repair count of zero.
- R2: A byte with any one of its eight bits flipped is repaired. Its message bits are restored, and it adds one to the repair count.
- R3: A byte that passes the all-bits group but fails any of the first three groups cannot be repaired. The reject strobe then goes high for one cycle, on the clock edge after the edge that took the byte. The commit strobe stays low and the output image keeps its previous value.
- R4: Output bytes 1, 2, 3 and 4 hold the message bits of positions 16/17, 18/19, 20/21 and 22/23. The first position of each pair fills the upper nibble and the second fills the lower nibble. Within a nibble, message bit 0 is the most significant bit. Output byte k occupies out_buf[8k-1:8k-8].
- R5: Output byte 5 holds positions 14 (upper nibble) and 15 (lower nibble). Output byte 6 holds positions 24 (upper) and 25 (lower). The nibble bit order is the same as in R4.
- R6: Output byte 7 holds position 13's message bits in its upper nibble and 1111 in its lower nibble. Output bytes 8 to 16 read 0xFF.
- R7: The commit strobe is high for exactly one cycle, on the clock edge after the edge that took position 25. The output image changes only together with that strobe.
- R8: At each commit, stat_corr equals the number of bytes of that packet that needed a repair.
- R9: While idle, bytes at any position other than 13 are ignored. No strobe fires and the image is unchanged.
- R10: During collection, a byte whose position is not the one following the previous byte rejects the packet, with the same effects as R3.
- R11: After reset, the image is all zeros, both strobes are low and stat_corr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A packet byte is present this cycle |
| in_idx | input | 6 | Packet position of the byte |
| in_code | input | 8 | Protected byte as received, bit 0 first on the line |
| out_buf | output | 128 | Sixteen-byte output image, byte 1 in the low bits |
| commit_stb | output | 1 | One-cycle pulse when a new image is loaded |
| reject_stb | output | 1 | One-cycle pulse when a packet is dropped |
| stat_corr | output | 4 | Repaired-byte count of the last finished packet |

## Verification
The bench builds the block with its defaults: first position 13, thirteen protected bytes, sixteen output bytes and a six-bit position field. These values give the full packet span, so every pairing of R4 to R6 appears, as do the padding bytes and the largest repair count of 13. With a six-bit position the bench can also present positions below 13 and above 25 while the block is idle. The table drives whole packets that carry injected single-bit faults at chosen bit positions, including parity-only faults. Directed cases then cover two-bit faults, a skipped position, and stray bytes while idle.

// File: rtl/ham84_pkg.sv
package ham84_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COLLECT,
        S_COMMIT,
        S_REJECT
    } state_t;

    // slot kinds of an output byte
    localparam int SLOT_PAIR = 0;  // two message nibbles
    localparam int SLOT_HIGH = 1;  // one nibble, lower half padded with ones
    localparam int SLOT_FILL = 2;  // constant 0xFF

    // kind of output byte k (zero based)
    function automatic int slot_kind(input int k);
        if (k < 6) return SLOT_PAIR;
        if (k == 6) return SLOT_HIGH;
        return SLOT_FILL;
    endfunction

    // nibble offset (from the first packet position) feeding the upper half
    function automatic int slot_hi(input int k);
        case (k)
            0: return 3;
            1: return 5;
            2: return 7;
            3: return 9;
            4: return 1;
            5: return 11;
            default: return 0;
        endcase
    endfunction

    // nibble offset feeding the lower half
    function automatic int slot_lo(input int k);
        return slot_hi(k) + 1;
    endfunction

    // message bit 0 lands in the most significant position of the nibble
    function automatic logic [3:0] msb_first(input logic [3:0] n);
        return {n[0], n[1], n[2], n[3]};
    endfunction

endpackage

// File: rtl/ham84_dec.sv
module ham84_dec (
    input  logic [7:0] code_i,
    output logic [3:0] nib_o,
    output logic       fix_o,
    output logic       bad_o
);
    logic       grp_a;
    logic       grp_b;
    logic       grp_c;
    logic       grp_all;
    logic [2:0] syn;
    logic [3:0] flip;

    always_comb begin
        grp_a   = ^{code_i[0], code_i[1], code_i[5], code_i[7]};
        grp_b   = ^{code_i[1], code_i[2], code_i[3], code_i[7]};
        grp_c   = ^{code_i[1], code_i[3], code_i[4], code_i[5]};
        grp_all = ^code_i;
        // a failing group reads as 1 in the syndrome
        syn = {~grp_c, ~grp_b, ~grp_a};
        case (syn)
            3'b111:  flip = 4'b0001;  // bit 1
            3'b110:  flip = 4'b0010;  // bit 3
            3'b101:  flip = 4'b0100;  // bit 5
            3'b011:  flip = 4'b1000;  // bit 7
            default: flip = 4'b0000;  // a parity bit or no error
        endcase
        fix_o = ~grp_all;
        bad_o = grp_all & (syn != 3'b000);
        nib_o = {code_i[7], code_i[5], code_i[3], code_i[1]} ^ (grp_all ? 4'b0000 : flip);
    end

endmodule

// File: rtl/ham84_store.sv
module ham84_store #(
    parameter int NBYTES    = 13,
    parameter int IDX_W     = 6,
    parameter int FIRST_IDX = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [3:0]            nib_i,
    output logic [4*NBYTES-1:0]   nibs_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        logic [3:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we_i && idx_i == IDX_W'(FIRST_IDX + g)) begin
                slot_q <= nib_i;
            end
        end
        assign nibs_o[4*g +: 4] = slot_q;
    end

endmodule

// File: rtl/ham84_pack.sv
module ham84_pack #(
    parameter int NBYTES  = 13,
    parameter int NUM_OUT = 16
) (
    input  logic [4*NBYTES-1:0]  nibs_i,
    output logic [8*NUM_OUT-1:0] image_o
);
    import ham84_pkg::*;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam int KIND = slot_kind(k);
        localparam int HI   = slot_hi(k);
        localparam int LO   = slot_lo(k);
        if (KIND == SLOT_PAIR) begin : g_pair
            assign image_o[8*k +: 8] = {msb_first(nibs_i[4*HI +: 4]), msb_first(nibs_i[4*LO +: 4])};
        end else if (KIND == SLOT_HIGH) begin : g_high
            assign image_o[8*k +: 8] = {msb_first(nibs_i[4*HI +: 4]), 4'hF};
        end else begin : g_fill
            assign image_o[8*k +: 8] = 8'hFF;
        end
    end

endmodule

// File: rtl/ham84_packer.sv
module ham84_packer #(
    parameter int FIRST_IDX = 13,
    parameter int NBYTES    = 13,
    parameter int NUM_OUT   = 16,
    parameter int IDX_W     = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [IDX_W-1:0]              in_idx,
    input  logic [7:0]                    in_code,
    output logic [8*NUM_OUT-1:0]          out_buf,
    output logic                          commit_stb,
    output logic                          reject_stb,
    output logic [$clog2(NBYTES+1)-1:0]   stat_corr
);
    import ham84_pkg::*;

    localparam int LAST_IDX = FIRST_IDX + NBYTES - 1;
    localparam int CNT_W    = $clog2(NBYTES + 1);
    localparam int BUF_W    = 8 * NUM_OUT;

    state_t                 state;
    state_t                 state_nx;
    logic [IDX_W-1:0]       exp_idx;
    logic [CNT_W-1:0]       corr_cnt;
    logic [3:0]             dec_nib;
    logic                   dec_fix;
    logic                   dec_bad;
    logic                   is_first;
    logic                   is_last;
    logic                   accept;
    logic [4*NBYTES-1:0]    nibs;
    logic [BUF_W-1:0]       image;

    ham84_dec u_dec (
        .code_i (in_code),
        .nib_o  (dec_nib),
        .fix_o  (dec_fix),
        .bad_o  (dec_bad)
    );

    ham84_store #(
        .NBYTES    (NBYTES),
        .IDX_W     (IDX_W),
        .FIRST_IDX (FIRST_IDX)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (accept),
        .idx_i  (in_idx),
        .nib_i  (dec_nib),
        .nibs_o (nibs)
    );

    ham84_pack #(
        .NBYTES  (NBYTES),
        .NUM_OUT (NUM_OUT)
    ) u_pack (
        .nibs_i  (nibs),
        .image_o (image)
    );

    assign is_first = (in_idx == IDX_W'(FIRST_IDX));
    assign is_last  = (in_idx == IDX_W'(LAST_IDX));
    assign accept   = in_valid && !dec_bad &&
                      ((state == S_IDLE && is_first) ||
                       (state == S_COLLECT && in_idx == exp_idx));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (in_valid && is_first) begin
                    state_nx = dec_bad ? S_REJECT : S_COLLECT;
                end
            end
            S_COLLECT: begin
                if (in_valid) begin
                    if (dec_bad || in_idx != exp_idx) begin
                        state_nx = S_REJECT;
                    end else if (is_last) begin
                        state_nx = S_COMMIT;
                    end
                end
            end
            S_COMMIT: state_nx = S_IDLE;
            S_REJECT: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // packet bookkeeping: expected position and repair tally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_idx  <= '0;
            corr_cnt <= '0;
        end else if (accept) begin
            exp_idx  <= in_idx + 1'b1;
            corr_cnt <= (state == S_IDLE) ? CNT_W'(dec_fix) : corr_cnt + CNT_W'(dec_fix);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_buf    <= '0;
            commit_stb <= 1'b0;
            reject_stb <= 1'b0;
            stat_corr  <= '0;
        end else begin
            commit_stb <= (state == S_COMMIT);
            reject_stb <= (state == S_REJECT);
            if (state == S_COMMIT) begin
                out_buf <= image;
            end
            if (state == S_COMMIT || state == S_REJECT) begin
                stat_corr <= corr_cnt;
            end
        end
    end

endmodule

// File: rtl/ham84_packer_chk.sv
module ham84_packer_chk #(
    parameter int FIRST_IDX = 13,
    parameter int NBYTES    = 13,
    parameter int NUM_OUT   = 16,
    parameter int IDX_W     = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [IDX_W-1:0]              in_idx,
    input logic [8*NUM_OUT-1:0]          out_buf,
    input logic                          commit_stb,
    input logic                          reject_stb,
    input logic [$clog2(NBYTES+1)-1:0]   stat_corr
);
    localparam int LAST_IDX = FIRST_IDX + NBYTES - 1;
    localparam int CNT_W    = $clog2(NBYTES + 1);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_stb && reject_stb));

    p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> !commit_stb);

    p_commit_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> ($past(in_valid, 2) && $past(in_idx, 2) == IDX_W'(LAST_IDX)));

    p_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |-> $stable(out_buf));

    p_reject_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reject_stb |=> !reject_stb);

    p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> (out_buf[51:48] == 4'hF && &out_buf[8*NUM_OUT-1:56]));

    p_corr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> stat_corr <= CNT_W'(NBYTES));

endmodule

bind ham84_packer ham84_packer_chk #(
    .FIRST_IDX (FIRST_IDX),
    .NBYTES    (NBYTES),
    .NUM_OUT   (NUM_OUT),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_idx     (in_idx),
    .out_buf    (out_buf),
    .commit_stb (commit_stb),
    .reject_stb (reject_stb),
    .stat_corr  (stat_corr)
);

// File: tb/ham84_packer_test.sv
`timescale 1ns/1ps
module ham84_packer_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [5:0]   in_idx = '0;
    logic [7:0]   in_code = '0;
    logic [127:0] out_buf;
    logic         commit_stb;
    logic         reject_stb;
    logic [3:0]   stat_corr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ham84_packer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_idx     (in_idx),
        .in_code    (in_code),
        .out_buf    (out_buf),
        .commit_stb (commit_stb),
        .reject_stb (reject_stb),
        .stat_corr  (stat_corr)
    );

    // nibbles (offset 0 = position 13 in the low bits), fault mask, fault bit
    localparam logic [67:0] TAB [0:4] = '{
        {52'h0123456789ABC, 13'h0000, 3'd0},
        {52'hFEDCBA9876543, 13'h1FFF, 3'd1},
        {52'h5A5A5A5A5A5A5, 13'h0001, 3'd6},
        {52'h3C3C3C3C3C3C3, 13'h1000, 3'd7},
        {52'h0F1E2D3C4B5A6, 13'h0AAA, 3'd0}
    };

    function automatic logic [7:0] enc(input logic [3:0] n);
        logic [7:0] c;
        c[1] = n[0]; c[3] = n[1]; c[5] = n[2]; c[7] = n[3];
        c[0] = ~(n[0] ^ n[2] ^ n[3]);
        c[2] = ~(n[0] ^ n[1] ^ n[3]);
        c[4] = ~(n[0] ^ n[1] ^ n[2]);
        c[6] = 1'b0;
        c[6] = ~(^c);
        return c;
    endfunction

    function automatic logic [3:0] rv(input logic [3:0] n);
        return {n[0], n[1], n[2], n[3]};
    endfunction

    function automatic logic [127:0] expect_img(input logic [51:0] nb);
        logic [127:0] e;
        e = {128{1'b1}};
        e[7:0]   = {rv(nb[12 +: 4]), rv(nb[16 +: 4])};
        e[15:8]  = {rv(nb[20 +: 4]), rv(nb[24 +: 4])};
        e[23:16] = {rv(nb[28 +: 4]), rv(nb[32 +: 4])};
        e[31:24] = {rv(nb[36 +: 4]), rv(nb[40 +: 4])};
        e[39:32] = {rv(nb[4 +: 4]),  rv(nb[8 +: 4])};
        e[47:40] = {rv(nb[44 +: 4]), rv(nb[48 +: 4])};
        e[55:48] = {rv(nb[0 +: 4]),  4'hF};
        return e;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [5:0] idx, input logic [7:0] code);
        in_valid = 1'b1;
        in_idx   = idx;
        in_code  = code;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [51:0] nb, input logic [12:0] mask, input logic [2:0] pos);
        for (int i = 0; i < 13; i++) begin
            logic [7:0] c;
            c = enc(nb[4*i +: 4]);
            if (mask[i]) c[pos] = ~c[pos];
            put(6'(13 + i), c);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [127:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset image", out_buf, '0);
        chk("R11 reset strobes", {commit_stb, reject_stb}, 0);
        chk("R11 reset count", stat_corr, 0);

        // table walk: whole packets with injected single-bit faults
        for (int t = 0; t < 5; t++) begin
            logic [51:0] nb;
            logic [12:0] mask;
            logic [2:0]  pos;
            logic [127:0] e;
            {nb, mask, pos} = TAB[t];
            e = expect_img(nb);
            send_pkt(nb, mask, pos);
            chk("R7 commit not before next edge", commit_stb, 0);
            @(negedge clk);
            chk("R7 commit strobe", commit_stb, 1);
            chk("R4 bytes 1-4", out_buf[31:0], e[31:0]);
            chk("R5 bytes 5-6", out_buf[47:32], e[47:32]);
            chk("R6 byte 7 and fill", out_buf[127:48], e[127:48]);
            chk(t == 0 ? "R1 count clean" : "R2 R8 repair count", stat_corr, $countones(mask));
            @(negedge clk);
            chk("R7 strobe single cycle", commit_stb, 0);
            chk("R7 image stable", out_buf, e);
        end
        prev = out_buf;

        // R3: two-bit fault at position 20
        for (int i = 0; i < 7; i++) put(6'(13 + i), enc(4'(i)));
        begin
            logic [7:0] c;
            c = enc(4'h9);
            c[1] = ~c[1];
            c[3] = ~c[3];
            put(6'd20, c);
        end
        @(negedge clk);
        chk("R3 reject strobe", reject_stb, 1);
        chk("R3 no commit", commit_stb, 0);
        chk("R3 image kept", out_buf, prev);
        @(negedge clk);
        chk("R3 reject single cycle", reject_stb, 0);

        // R10: skipped position
        put(6'd13, enc(4'h1));
        put(6'd14, enc(4'h2));
        put(6'd16, enc(4'h3));
        @(negedge clk);
        chk("R10 reject on gap", reject_stb, 1);
        chk("R10 image kept", out_buf, prev);
        @(negedge clk);

        // R9: stray bytes while idle
        for (int i = 14; i <= 25; i++) begin
            put(6'(i), enc(4'hA));
            chk("R9 no strobe while idle", {commit_stb, reject_stb}, 0);
        end
        put(6'd40, enc(4'h5));
        @(negedge clk);
        chk("R9 no strobe after strays", {commit_stb, reject_stb}, 0);
        chk("R9 image unchanged", out_buf, prev);

        // block still accepts a proper packet afterwards
        send_pkt(52'h13579BDF02468, 13'h0000, 3'd0);
        @(negedge clk);
        chk("R7 commit after recovery", commit_stb, 1);
        chk("R4 image after recovery", out_buf, expect_img(52'h13579BDF02468));

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule